// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers event signals from six interrupt sources: one external pin, an analog-to-digital converter, three PWM/timer units and a serial port. Each event is held in its own pending latch. A per-source enable bit in an 8-bit configuration register decides whether a pending event may ask for service. A masked event is not dropped. It waits in its latch until software opens its enable bit.

An unmasked pending event raises a global pending flag. The request to the processor core is a separate signal, and it is issued only when two independent global gates are both open. The user gate belongs to the main program. The macro gate is for compiler-generated code that must not be interrupted. Each gate has its own pair of set and clear commands. When a request is issued, the block presents the index of the highest-priority source that is both pending and enabled. A one-cycle acknowledge from the core clears that source's pending latch. The external pin is synchronised first, and a configuration bit selects whether its rising or its falling edge counts as an event.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the configuration register reads 0x00, both global gates are closed, all pending latches are empty, and `irq_pending`, `irq_req` and `irq_idx` are all 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration register, and `cfg_rdata` returns the stored value. Bit 7 is unused and always reads 0. Bits 0 to 5 are the enables for the sources with indices 0 to 5, and bit 6 is the external polarity bit.
- R3: A source whose enable bit is 0 raises neither `irq_pending` nor `irq_req`, but its event stays latched. If the enable bit is later set to 1, the source requests service without a new event.
- R4: `irq_pending` is high whenever at least one pending source is enabled, whatever the state of the global gates.
- R5: `irq_req` is high only while both the user gate and the macro gate are open. `user_gie_set`/`user_gie_clr` open and close the user gate, and `macro_gie_set`/`macro_gie_clr` do the same for the macro gate. If set and clear arrive in the same cycle, clear wins.
- R6: Source indices are 0 = external pin, 1 = A/D (`periph_evt[0]`), 2 = timer0 (`periph_evt[1]`), 3 = timer1 (`periph_evt[2]`), 4 = timer2 (`periph_evt[3]`), 5 = serial (`periph_evt[4]`). A lower index has higher priority. `irq_idx` shows the lowest enabled pending index and reads 0 when nothing is pending.
- R7: With polarity bit 0, a rising edge on `ext_irq_pin` is the event. With polarity bit 1, a falling edge is the event. The opposite edge does nothing. A pin change made before clock edge k shows on the outputs after edge k+2.
- R8: `irq_ack` together with `irq_req` clears only the pending latch of the index shown on `irq_idx`. If a new event from that same source arrives in the acknowledge cycle, the latch stays set.
- R9: Writing 0x06 to the configuration register enables only the A/D (index 1) and timer0 (index 2) sources.
- R10: A `periph_evt` bit that is high at clock edge k is reflected on `irq_pending`, `irq_req` and `irq_idx` right after edge k, and an acknowledge at edge k takes effect on those outputs at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_pin | input | 1 | Asynchronous external interrupt pin |
| periph_evt | input | 5 | Peripheral event strobes: A/D, timer0, timer1, timer2, serial |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register readback |
| user_gie_set | input | 1 | Open the user global gate |
| user_gie_clr | input | 1 | Close the user global gate |
| macro_gie_set | input | 1 | Open the macro global gate |
| macro_gie_clr | input | 1 | Close the macro global gate |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_pending | output | 1 | Global pending flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 3 | Index of the selected source |

## Verification
The bench first latches an event while its source is masked and then unmasks it. A design that dropped masked events would never request for that source, and one that ignored the mask would request too early. It opens one global gate at a time and also sends set and clear together, which catches a design that ORs the gates or lets set win. It acknowledges one source while a second is pending, and acknowledges again while the same source fires a new event. A wrong clear index or a clear that beats the set shows up as a missing or wrong index. It also drives the opposite edge of the external pin under both polarities, and checks the exact cycle of the synchroniser latency.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 6;
  localparam int IDX_W     = 3;
  localparam int CFG_W     = 8;
  localparam int NUM_PERIPH = NUM_SRC - 1;
  localparam int POL_BIT   = NUM_SRC;
  localparam int SPARE_BIT = CFG_W - 1;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin_i;
  end

  genvar s;
  generate
    for (s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  assign pulse_o = fall_sel_i ? (prev_q & ~cur) : (cur & ~prev_q);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R7
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_q_o,
  output logic [N-1:0]  pend_d_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] clr_vec;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      assign clr_vec[i]  = clr_en_i && (clr_idx_i == IW'(i));
      assign pend_d_o[i] = (pend_q[i] & ~clr_vec[i]) | evt_i[i];

      always_ff @(posedge clk) begin
        if (rst) pend_q[i] <= 1'b0;
        else     pend_q[i] <= pend_d_o[i];
      end

      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_q[i] && !clr_vec[i]) |=> pend_q[i]); // R3
    end
  endgenerate

  assign pend_q_o = pend_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && clr_idx_i < IW'(N) && !evt_i[clr_idx_i])
      |=> !pend_q[$past(clr_idx_i)]); // R8
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] above;
  logic [N-1:0] grant;

  assign above[0] = 1'b0;
  genvar i;
  generate
    for (i = 1; i < N; i++) begin : g_chain
      assign above[i] = above[i-1] | req_i[i-1];
    end
  endgenerate

  assign grant = req_i & ~above;
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) idx_o = idx_o | IW'(k);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_irq_pin,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic                  cfg_we,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [CFG_W-1:0]      cfg_rdata,
  input  logic                  user_gie_set,
  input  logic                  user_gie_clr,
  input  logic                  macro_gie_set,
  input  logic                  macro_gie_clr,
  input  logic                  irq_ack,
  output logic                  irq_pending,
  output logic                  irq_req,
  output logic [IDX_W-1:0]      irq_idx
);
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic               user_q, user_d;
  logic               macro_q, macro_d;
  logic               ext_pulse;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] live;
  logic               any_live;
  logic [IDX_W-1:0]   sel_idx;
  logic               clr_en;
  logic               pend_r, req_r;
  logic [IDX_W-1:0]   idx_r;

  // configuration register; spare bit is never stored
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d = cfg_wdata;
      cfg_d[SPARE_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end
  assign cfg_rdata = cfg_q;

  // two global gates, clear dominates
  always_comb begin
    user_d = user_q;
    if (user_gie_set) user_d = 1'b1;
    if (user_gie_clr) user_d = 1'b0;
    macro_d = macro_q;
    if (macro_gie_set) macro_d = 1'b1;
    if (macro_gie_clr) macro_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q  <= 1'b0;
      macro_q <= 1'b0;
    end else begin
      user_q  <= user_d;
      macro_q <= macro_d;
    end
  end

  irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (ext_irq_pin),
    .fall_sel_i (cfg_q[POL_BIT]),
    .pulse_o    (ext_pulse)
  );

  assign evt    = {periph_evt, ext_pulse};
  assign clr_en = irq_ack & req_r;

  irq_pend_bank #(.N(NUM_SRC), .IW(IDX_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .clr_en_i  (clr_en),
    .clr_idx_i (idx_r),
    .pend_q_o  (pend_q),
    .pend_d_o  (pend_d)
  );

  assign live = pend_d & cfg_d[NUM_SRC-1:0];

  irq_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
    .req_i (live),
    .any_o (any_live),
    .idx_o (sel_idx)
  );

  // outputs registered from next-state values so they track the latches
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_r <= 1'b0;
      req_r  <= 1'b0;
      idx_r  <= '0;
    end else begin
      pend_r <= any_live;
      req_r  <= any_live & user_d & macro_d;
      idx_r  <= sel_idx;
    end
  end

  assign irq_pending = pend_r;
  assign irq_req     = req_r;
  assign irq_idx     = idx_r;

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (user_q && macro_q)); // R5
  AST_REQ_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_pending); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_idx < IDX_W'(NUM_SRC))); // R6
  AST_SEL_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> pend_q[irq_idx]); // R6
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata[SPARE_BIT] == 1'b0)); // R2
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_irq_pin = 1'b0;
  logic [4:0] periph_evt = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       user_gie_set = 1'b0, user_gie_clr = 1'b0;
  logic       macro_gie_set = 1'b0, macro_gie_clr = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_pending, irq_req;
  logic [2:0] irq_idx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_irq_pin(ext_irq_pin), .periph_evt(periph_evt),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .user_gie_set(user_gie_set), .user_gie_clr(user_gie_clr),
    .macro_gie_set(macro_gie_set), .macro_gie_clr(macro_gie_clr),
    .irq_ack(irq_ack), .irq_pending(irq_pending), .irq_req(irq_req),
    .irq_idx(irq_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ext_irq_pin = 1'b0;
    step(4);
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(1); cfg_we = 1'b0;
  endtask

  task automatic gates_on();
    user_gie_set = 1'b1; macro_gie_set = 1'b1; step(1);
    user_gie_set = 1'b0; macro_gie_set = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] v);
    periph_evt = v; step(1); periph_evt = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic expect_req(input string tag, input bit r, input int idx);
    chk(irq_req == r, tag, irq_req, r);
    if (r) chk(irq_idx == idx, tag, irq_idx, idx);
  endtask

  task automatic t_reset();
    do_reset();
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk(irq_req == 1'b0, "R1 req", irq_req, 0);
    chk(irq_pending == 1'b0, "R1 pending", irq_pending, 0);
    chk(irq_idx == 3'd0, "R1 idx", irq_idx, 0);
  endtask

  task automatic t_cfg();
    do_reset();
    wr_cfg(8'hFF);
    chk(cfg_rdata == 8'h7F, "R2 spare bit", cfg_rdata, 8'h7F);
    wr_cfg(8'h25);
    chk(cfg_rdata == 8'h25, "R2 readback", cfg_rdata, 8'h25);
  endtask

  task automatic t_mask_six();
    do_reset();
    gates_on();
    wr_cfg(8'h06);
    pulse(5'b00100); // timer1 masked
    expect_req("R9 timer1 masked", 1'b0, 0);
    chk(irq_pending == 1'b0, "R3 masked no pending flag", irq_pending, 0);
    pulse(5'b10000); // serial masked
    expect_req("R9 serial masked", 1'b0, 0);
    pulse(5'b00010);
    expect_req("R9 timer0 enabled", 1'b1, 2);
    ack();
    expect_req("R8 timer0 cleared", 1'b0, 0);
    pulse(5'b00001);
    expect_req("R9 adc enabled", 1'b1, 1);
    ack();
    wr_cfg(8'h0E); // unmask timer1
    expect_req("R3 held event served", 1'b1, 3);
    ack();
    expect_req("R3 after ack", 1'b0, 0);
  endtask

  task automatic t_gates();
    do_reset();
    wr_cfg(8'h3F);
    pulse(5'b00001);
    chk(irq_pending == 1'b1, "R4 pending gates closed", irq_pending, 1);
    expect_req("R5 both closed", 1'b0, 0);
    user_gie_set = 1'b1; step(1); user_gie_set = 1'b0;
    expect_req("R5 user only", 1'b0, 0);
    macro_gie_set = 1'b1; step(1); macro_gie_set = 1'b0;
    expect_req("R5 both open", 1'b1, 1);
    macro_gie_set = 1'b1; macro_gie_clr = 1'b1; step(1);
    macro_gie_set = 1'b0; macro_gie_clr = 1'b0;
    expect_req("R5 clear wins", 1'b0, 0);
    chk(irq_pending == 1'b1, "R4 still pending", irq_pending, 1);
    macro_gie_set = 1'b1; step(1); macro_gie_set = 1'b0;
    user_gie_clr = 1'b1; step(1); user_gie_clr = 1'b0;
    expect_req("R5 user closed", 1'b0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    gates_on();
    wr_cfg(8'h3F);
    ext_irq_pin = 1'b1; step(3);
    expect_req("R6 external alone", 1'b1, 0);
    pulse(5'b11111);
    expect_req("R6 external first", 1'b1, 0);
    for (int k = 1; k < 6; k++) begin
      ack();
      expect_req("R6 next in order", 1'b1, k);
    end
    ack();
    expect_req("R6 all served", 1'b0, 0);
    chk(irq_idx == 3'd0, "R6 idx idle", irq_idx, 0);
  endtask

  task automatic t_ext();
    do_reset();
    gates_on();
    wr_cfg(8'h01);
    ext_irq_pin = 1'b1; step(2);
    expect_req("R7 latency not early", 1'b0, 0);
    step(1);
    expect_req("R7 rising event", 1'b1, 0);
    ack();
    ext_irq_pin = 1'b0; step(5);
    expect_req("R7 falling ignored", 1'b0, 0);
    wr_cfg(8'h41);
    ext_irq_pin = 1'b1; step(5);
    expect_req("R7 rising ignored pol1", 1'b0, 0);
    ext_irq_pin = 1'b0; step(3);
    expect_req("R7 falling event", 1'b1, 0);
  endtask

  task automatic t_ack();
    do_reset();
    gates_on();
    wr_cfg(8'h3F);
    pulse(5'b00011);
    expect_req("R10 same-edge visible", 1'b1, 1);
    irq_ack = 1'b1; periph_evt = 5'b00001; step(1);
    irq_ack = 1'b0; periph_evt = '0;
    expect_req("R8 re-set on ack", 1'b1, 1);
    ack();
    expect_req("R8 only presented cleared", 1'b1, 2);
    ack();
    expect_req("R8 drained", 1'b0, 0);
    chk(irq_pending == 1'b0, "R8 pending flag", irq_pending, 0);
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_mask_six();
    t_gates();
    t_priority();
    t_ext();
    t_ack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule